// File: doc/BRIEF.md
# FIFO Fill-Level Status Flags

This block produces three active-low fill-level flags for a FIFO whose write and read sides run on unrelated clocks: almost-full, almost-empty and half-full. It does not hold any data. It watches the write pointer, which lives in the write-clock domain, and the read pointer and a marked read location, which live in the read-clock domain. Each side compares its own pointer with a Gray-coded, two-stage synchronised copy of the opposite pointer. The full offset `m` and the empty offset `n` are static inputs. After reset they are normally 7.

The pointers count words entering and leaving the FIFO as a whole, so the fill level is `wr_ptr - rd_ptr` modulo the pointer width. `D` is `2**ADDR_W`. When `fall_thru` is set, the word held in the output register also counts as stored. The usable capacity is then `D+1`, and every threshold moves up by one word.

`async_almost` chooses how the two almost flags are timed. In synchronous timing, almost-full is a write-clock register and almost-empty is a read-clock register. In asynchronous timing, each almost flag is set by a clock edge in one domain and released by a clock edge in the other. Half-full always works that way: writes set it and reads release it. When `retx_mode` is set, almost-full and half-full measure the write pointer against `mark_ptr` instead of the read pointer. Almost-empty keeps using the read pointer. All pointers are unsigned binary counters, `ADDR_W+2` bits wide.

Top module: `fifo_status_flags`

## Requirements
- R1: While `rst_n` is low all three flags are 1, and on the first write-clock and read-clock edges after release they are still 1.
- R2: With `fall_thru`=0 and no reads, `almost_full_n` goes to 0 on the write-clock edge that first sees a level of `D-m` words. It stays 1 at lower levels.
- R3: With `fall_thru`=1 and no reads, `almost_full_n` goes to 0 on the write-clock edge that first sees a level of `D+1-m` words.
- R4: Once the pointers are stable, `almost_empty_n` is 0 exactly when the level is at most `n` (`fall_thru`=0) or at most `n+1` (`fall_thru`=1).
- R5: With `fall_thru`=0, `half_full_n` goes to 0 on the write-clock edge that first sees a level of `D/2+1` words.
- R6: With `fall_thru`=1, `half_full_n` goes to 0 on the write-clock edge that first sees a level of `D/2+2` words.
- R7: With `async_almost`=0, a read that takes the level below the almost-full threshold leaves `almost_full_n` at 0 on that read edge. The flag returns to 1 a few write clocks later.
- R8: With `async_almost`=1, `almost_full_n` returns to 1 on the read-clock edge that takes the level below the almost-full threshold.
- R9: With `async_almost`=1, `almost_empty_n` goes to 0 on the read-clock edge that takes the level down to the almost-empty threshold. It never falls without a read-pointer change.
- R10: `half_full_n` returns to 1 on the read-clock edge that takes the level to half the capacity or less (`D/2` or `D/2+1`).
- R11: With `retx_mode`=1, almost-full and half-full use `wr_ptr - mark_ptr` as the level, while almost-empty keeps using `wr_ptr - rd_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_ptr | input | ADDR_W+2 | Count of words written (write domain) |
| rd_ptr | input | ADDR_W+2 | Count of words read (read domain) |
| mark_ptr | input | ADDR_W+2 | Marked read location for retransmit (read domain) |
| full_ofs | input | ADDR_W+1 | Almost-full offset m |
| empty_ofs | input | ADDR_W+1 | Almost-empty offset n |
| fall_thru | input | 1 | 1: output register counts as storage (capacity D+1) |
| async_almost | input | 1 | 1: almost flags set in one domain, released in the other |
| retx_mode | input | 1 | 1: write-side flags measure against mark_ptr |
| almost_full_n | output | 1 | Almost-full, active low |
| almost_empty_n | output | 1 | Almost-empty, active low |
| half_full_n | output | 1 | Half-full, active low |

## Verification
The hardest case to reach is a flag released by a clock edge in the opposite domain at the exact edge. The read side only releases a flag after its synchronised copy of the set event has arrived. To get there, the stimulus fills the FIFO and then waits several cycles in both domains. It then steps the read pointer one word at a time, sampling just after each read edge. This shows both the exact release in asynchronous timing and the held flag in synchronous timing. Retransmit is reached by reading past a mark that stays fixed, and then moving the mark.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

  // Level at or above which almost-full is active.
  function automatic int af_limit(int depth, bit fwft, int m_ofs);
    return depth + int'(fwft) - m_ofs;
  endfunction

  // Level at or below which almost-empty is active.
  function automatic int ae_limit(int n_ofs, bit fwft);
    return n_ofs + int'(fwft);
  endfunction

  // Level strictly above which half-full is active.
  function automatic int hf_limit(int depth, bit fwft);
    return depth / 2 + int'(fwft);
  endfunction

endpackage

// File: rtl/flag_ptr_sync.sv
module flag_ptr_sync #(
  parameter int PW     = 6,
  parameter int SYNC_N = 2
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_bin,
  output logic [PW-1:0] dst_bin
);

  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] gray_src;
  logic [PW-1:0] stage [SYNC_N];

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) gray_src <= '0;
    else        gray_src <= to_gray(src_bin);

  always_ff @(posedge dst_clk or negedge rst_n)
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= gray_src;

  for (genvar s = 1; s < SYNC_N; s++) begin : g_stage
    always_ff @(posedge dst_clk or negedge rst_n)
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
  end

  assign dst_bin = from_gray(stage[SYNC_N-1]);

endmodule

// File: rtl/flag_xdomain.sv
module flag_xdomain #(
  parameter int SYNC_N = 2
) (
  input  logic set_clk,
  input  logic clr_clk,
  input  logic rst_n,
  input  logic set_cond,
  input  logic clr_cond,
  output logic set_evt,
  output logic clr_evt,
  output logic flag_n
);

  logic set_tog, clr_tog;
  logic [SYNC_N-1:0] clr_seen, set_seen;

  always_ff @(posedge set_clk or negedge rst_n)
    if (!rst_n) clr_seen <= '0;
    else        clr_seen <= {clr_seen[SYNC_N-2:0], clr_tog};

  always_ff @(posedge clr_clk or negedge rst_n)
    if (!rst_n) set_seen <= '0;
    else        set_seen <= {set_seen[SYNC_N-2:0], set_tog};

  // Set only while the set side believes the flag is inactive.
  assign set_evt = set_cond && (set_tog == clr_seen[SYNC_N-1]);
  // Release only after the release side has seen the set.
  assign clr_evt = clr_cond && (set_seen[SYNC_N-1] != clr_tog);

  always_ff @(posedge set_clk or negedge rst_n)
    if (!rst_n)       set_tog <= 1'b0;
    else if (set_evt) set_tog <= ~set_tog;

  always_ff @(posedge clr_clk or negedge rst_n)
    if (!rst_n)       clr_tog <= 1'b0;
    else if (clr_evt) clr_tog <= ~clr_tog;

  assign flag_n = ~(set_tog ^ clr_tog);

endmodule

// File: rtl/fifo_status_flags.sv
module fifo_status_flags
  import fifo_flag_pkg::*;
#(
  parameter  int ADDR_W = 4,
  parameter  int SYNC_N = 2,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PW     = ADDR_W + 2,
  localparam int OW     = ADDR_W + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] rd_ptr,
  input  logic [PW-1:0] mark_ptr,
  input  logic [OW-1:0] full_ofs,
  input  logic [OW-1:0] empty_ofs,
  input  logic          fall_thru,
  input  logic          async_almost,
  input  logic          retx_mode,
  output logic          almost_full_n,
  output logic          almost_empty_n,
  output logic          half_full_n
);

  logic [PW-1:0] rd_at_w, mark_at_w, wr_at_r;
  logic [PW-1:0] lvl_w, lvl_we, lvl_rm, lvl_re;
  int            af_thr, ae_thr, hf_thr;
  logic          af_hit_w, af_hit_r, ae_hit_w, ae_hit_r, hf_hit_w, hf_hit_r;
  logic          af_sync_n, ae_sync_n, af_x_n, ae_x_n;
  logic          af_set_evt, af_clr_evt, ae_set_evt, ae_clr_evt;
  logic          hf_set_evt, hf_clr_evt;

  flag_ptr_sync #(.PW(PW), .SYNC_N(SYNC_N)) u_rd_to_w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n), .src_bin(rd_ptr), .dst_bin(rd_at_w));
  flag_ptr_sync #(.PW(PW), .SYNC_N(SYNC_N)) u_mark_to_w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n), .src_bin(mark_ptr), .dst_bin(mark_at_w));
  flag_ptr_sync #(.PW(PW), .SYNC_N(SYNC_N)) u_wr_to_r (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n), .src_bin(wr_ptr), .dst_bin(wr_at_r));

  // Fill levels as seen by each side; retransmit redirects write-side flags to the mark.
  assign lvl_w  = wr_ptr - (retx_mode ? mark_at_w : rd_at_w);
  assign lvl_we = wr_ptr - rd_at_w;
  assign lvl_rm = wr_at_r - (retx_mode ? mark_ptr : rd_ptr);
  assign lvl_re = wr_at_r - rd_ptr;

  assign af_thr = af_limit(DEPTH, fall_thru, int'(full_ofs));
  assign ae_thr = ae_limit(int'(empty_ofs), fall_thru);
  assign hf_thr = hf_limit(DEPTH, fall_thru);

  assign af_hit_w = int'(lvl_w)  >= af_thr;
  assign af_hit_r = int'(lvl_rm) >= af_thr;
  assign hf_hit_w = int'(lvl_w)  >  hf_thr;
  assign hf_hit_r = int'(lvl_rm) >  hf_thr;
  assign ae_hit_w = int'(lvl_we) <= ae_thr;
  assign ae_hit_r = int'(lvl_re) <= ae_thr;

  // Synchronous timing: one register per flag in its own domain.
  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) af_sync_n <= 1'b1;
    else        af_sync_n <= !af_hit_w;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) ae_sync_n <= 1'b1;
    else        ae_sync_n <= !ae_hit_r;

  // Cross-domain set/release flags.
  flag_xdomain #(.SYNC_N(SYNC_N)) u_af_x (
    .set_clk(wclk), .clr_clk(rclk), .rst_n(rst_n),
    .set_cond(af_hit_w), .clr_cond(!af_hit_r),
    .set_evt(af_set_evt), .clr_evt(af_clr_evt), .flag_n(af_x_n));

  flag_xdomain #(.SYNC_N(SYNC_N)) u_ae_x (
    .set_clk(rclk), .clr_clk(wclk), .rst_n(rst_n),
    .set_cond(ae_hit_r), .clr_cond(!ae_hit_w),
    .set_evt(ae_set_evt), .clr_evt(ae_clr_evt), .flag_n(ae_x_n));

  flag_xdomain #(.SYNC_N(SYNC_N)) u_hf_x (
    .set_clk(wclk), .clr_clk(rclk), .rst_n(rst_n),
    .set_cond(hf_hit_w), .clr_cond(!hf_hit_r),
    .set_evt(hf_set_evt), .clr_evt(hf_clr_evt), .flag_n(half_full_n));

  assign almost_full_n  = async_almost ? af_x_n : af_sync_n;
  assign almost_empty_n = async_almost ? ae_x_n : ae_sync_n;

endmodule

// File: rtl/fifo_status_flags_chk.sv
module fifo_status_flags_chk #(
  parameter int PW = 6
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          async_almost,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          almost_full_n,
  input logic          almost_empty_n,
  input logic          half_full_n
);

  // R1: write-clocked flags still inactive at the first write edge after reset.
  assert_reset_idle_w_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(rst_n) |-> (almost_full_n && half_full_n));

  // R1: almost-empty still inactive at the first read edge after reset.
  assert_reset_idle_r_R1: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(rst_n) |-> almost_empty_n);

  // R2: in synchronous timing, almost-full only asserts after the write pointer moved.
  assert_af_after_write_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (!async_almost && $past(rst_n, 2) && $fell(almost_full_n))
      |-> ($past(wr_ptr) != $past(wr_ptr, 2)));

  // R9: almost-empty only asserts after the read pointer moved.
  assert_ae_after_read_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    ($past(rst_n, 2) && $fell(almost_empty_n))
      |-> ($past(rd_ptr) != $past(rd_ptr, 2)));

endmodule

bind fifo_status_flags fifo_status_flags_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .async_almost(async_almost),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .almost_full_n(almost_full_n),
  .almost_empty_n(almost_empty_n), .half_full_n(half_full_n));

// File: tb/test_fifo_status_flags.sv
`timescale 1ns/1ps
module test_fifo_status_flags;
  localparam int AW = 4;
  localparam int PW = AW + 2;
  localparam int OW = AW + 1;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] wr_ptr = '0, rd_ptr = '0, mark_ptr = '0;
  logic [OW-1:0] full_ofs = OW'(7), empty_ofs = OW'(7);
  logic          fall_thru = 1'b0, async_almost = 1'b0, retx_mode = 1'b0;
  logic          almost_full_n, almost_empty_n, half_full_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 wclk = ~wclk;   // 50 MHz write clock
  always #14 rclk = ~rclk;

  fifo_status_flags #(.ADDR_W(AW)) i_fifo_status_flags (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .mark_ptr(mark_ptr), .full_ofs(full_ofs), .empty_ofs(empty_ofs),
    .fall_thru(fall_thru), .async_almost(async_almost), .retx_mode(retx_mode),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
    .half_full_n(half_full_n));

  // Scoreboard: bit order {af, ae, hf}.
  typedef struct { logic [2:0] care; logic [2:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [2:0] act;
      e = exp_q.pop_front();
      act = {almost_full_n, almost_empty_n, half_full_n};
      checks++;
      if ((act & e.care) != (e.val & e.care)) begin
        errors++;
        $display("FAIL %s: af/ae/hf actual %b expected %b (mask %b)", e.tag, act, e.val, e.care);
      end
    end
  end

  task automatic expect_flags(input logic [2:0] care, input logic [2:0] val, input string tag);
    exp_t e;
    e.care = care; e.val = val; e.tag = tag;
    exp_q.push_back(e);
    ->chk_ev;
    #0;
  endtask

  task automatic reset_dut(input logic ft, input logic asy, input logic rt);
    rst_n = 1'b0;
    fall_thru = ft; async_almost = asy; retx_mode = rt;
    wr_ptr = '0; rd_ptr = '0; mark_ptr = '0;
    repeat (3) @(posedge wclk);
    #3 expect_flags(3'b111, 3'b111, "R1 flags inactive in reset");
    @(negedge wclk) rst_n = 1'b1;
  endtask

  task automatic do_write();
    @(negedge wclk) wr_ptr = wr_ptr + 1'b1;
    @(posedge wclk); #3;
  endtask

  task automatic do_read();
    @(negedge rclk) rd_ptr = rd_ptr + 1'b1;
    @(posedge rclk); #3;
  endtask

  task automatic settle();
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    #3;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-chain: run actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Standard mode, synchronous timing. D=16, m=n=7.
    reset_dut(1'b0, 1'b0, 1'b0);
    settle();
    expect_flags(3'b111, 3'b101, "R4 empty FIFO std");
    for (int k = 1; k <= 10; k++) begin
      do_write();
      expect_flags(3'b100, {!(k >= 9), 2'b00}, $sformatf("R2 almost-full std level %0d", k));
      expect_flags(3'b001, {2'b00, !(k >= 9)}, $sformatf("R5 half-full std level %0d", k));
      if (k == 7 || k == 8) begin
        settle();
        expect_flags(3'b010, {1'b0, !(k <= 7), 1'b0}, $sformatf("R4 almost-empty std level %0d", k));
      end
    end
    settle();
    do_read();   // level 9
    expect_flags(3'b101, 3'b000, "R7 level 9 af/hf still low");
    do_read();   // level 8
    expect_flags(3'b100, 3'b000, "R7 sync af held on read edge");
    expect_flags(3'b001, 3'b001, "R10 half-full released on read edge std");
    settle();
    expect_flags(3'b100, 3'b100, "R7 sync af released after write clocks");

    // Fall-through mode, asynchronous timing.
    reset_dut(1'b1, 1'b1, 1'b0);
    settle();
    expect_flags(3'b111, 3'b101, "R4 empty FIFO fwft");
    for (int k = 1; k <= 11; k++) begin
      do_write();
      expect_flags(3'b100, {!(k >= 10), 2'b00}, $sformatf("R3 almost-full fwft level %0d", k));
      expect_flags(3'b001, {2'b00, !(k >= 10)}, $sformatf("R6 half-full fwft level %0d", k));
      if (k == 8 || k == 9) begin
        settle();
        expect_flags(3'b010, {1'b0, !(k <= 8), 1'b0}, $sformatf("R4 almost-empty fwft level %0d", k));
      end
    end
    settle();
    do_read();   // level 10
    expect_flags(3'b100, 3'b000, "R8 level 10 af still low");
    do_read();   // level 9
    expect_flags(3'b100, 3'b100, "R8 async af released on read edge");
    expect_flags(3'b011, 3'b011, "R10 half-full released fwft, ae high");
    do_read();   // level 8
    expect_flags(3'b010, 3'b000, "R9 async ae set on read edge");

    // Retransmit, standard mode, synchronous timing, mark at 0.
    reset_dut(1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= 10; k++) do_write();
    settle();
    expect_flags(3'b101, 3'b000, "R11 filled to 10 af/hf low");
    for (int k = 1; k <= 4; k++) do_read();
    settle();
    expect_flags(3'b111, 3'b000, "R11 af/hf follow mark, ae follows read ptr");
    @(negedge rclk) mark_ptr = rd_ptr;
    settle();
    expect_flags(3'b111, 3'b101, "R11 mark moved, af/hf released");

    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule